// File: doc/BRIEF.md
# Packed-Opcode Stack Processor Core

This block is a compact processor core that keeps its operands on a data stack rather than in a register file. Instructions have no operand fields. Every source and every destination is the top of the stack. A 32-bit instruction word carries six 5-bit opcodes. The core loads a word into a slot queue and drains it at one opcode per cycle. While it does so, a one-word prefetch buffer fetches the next word of the instruction stream.

A literal opcode takes the next word of the stream as data and pushes it, so that word is never decoded. When a word holds several literal opcodes, the words that follow it are claimed as literals in slot order. Branches write the instruction pointer from the stack. A taken branch flushes the slot queue and the prefetch buffer. Multiplication runs in a separate multi-cycle unit and leaves its product in a result register, which a later opcode pushes. Stack overflow or underflow is a fault that stops the core.

Top module: `stk_core`

## Requirements
- R1: Bits [4:0] of an instruction word form slot 0, bits [9:5] form slot 1, and so on up to slot 5. Bits [31:30] are ignored. Slots execute in ascending order, at most one per cycle. Code 0 is a no-op, and codes 18 to 31 also behave as no-ops.
- R2: Code 1 (literal) pushes the next unread word of the instruction stream. When a word holds N literal opcodes, the N words after it are consumed as literals in slot order and are never decoded.
- R3: Codes 2 ADD, 3 SUB (second minus top), 4 AND, 5 OR and 6 XOR replace the top two entries with their result. Code 7 NOT replaces the top entry with its bitwise inverse.
- R4: Code 8 duplicates the top entry, code 9 drops it, and code 10 swaps the top two entries.
- R5: Code 11 pops an address and pushes the data word at that address. Code 12 pops an address (the top), then pops the data, and writes the data to that address.
- R6: Code 13 pops a word address and jumps to it. Code 14 pops a target (the top), then pops a condition, and jumps when the condition is zero. A taken jump discards the remaining slots and any prefetched word.
- R7: Code 15 pops two entries and starts a multi-cycle multiplier whose low 32 bits land in a result register. Code 16 pushes that register and stalls until it is valid. A code 15 issued while the multiplier is busy stalls.
- R8: The stack holds 16 entries. An opcode that would underflow or overflow it sets a sticky fault flag, halts the core and leaves the stack unchanged.
- R9: Code 17 halts the core. The halted state is sticky. While halted, the core makes no instruction fetch and no data memory access.
- R10: After reset, depth is 0, halted and fault are low, and the first fetch is at word address 0.
- R11: A data memory read and a data memory write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_en | output | 1 | Instruction read request |
| imem_addr | output | 8 | Instruction word address |
| imem_data | input | 32 | Instruction word, valid one cycle after the request |
| dmem_re | output | 1 | Data read request |
| dmem_we | output | 1 | Data write request |
| dmem_addr | output | 8 | Data word address |
| dmem_wdata | output | 32 | Data to write |
| dmem_rdata | input | 32 | Read data, valid one cycle after the request |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Sticky stack overflow or underflow flag |
| depth | output | 5 | Number of stack entries in use |
| tos | output | 32 | Current top-of-stack entry |

## Verification
The assertions assume that both memories answer exactly one cycle after a request, and that reset is held for at least one clock edge before the core runs. The bench memories are synchronous arrays with this fixed latency, so the core never stalls on memory. Every test program ends in a halt or deliberately faults. A result-push opcode appears only after a multiply has been issued, so the push never waits on a result that will not arrive. Fetch addresses stay inside the 256-word program array.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,
    OP_LIT   = 5'd1,
    OP_ADD   = 5'd2,
    OP_SUB   = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOT   = 5'd7,
    OP_DUP   = 5'd8,
    OP_DROP  = 5'd9,
    OP_SWAP  = 5'd10,
    OP_LOAD  = 5'd11,
    OP_STORE = 5'd12,
    OP_JMP   = 5'd13,
    OP_JZ    = 5'd14,
    OP_MUL   = 5'd15,
    OP_PUSHR = 5'd16,
    OP_HALT  = 5'd17
  } op_e;
endpackage

// File: rtl/stk_fetch.sv
// Fetch pointer, one-word prefetch buffer and the slot queue of the current word.
module stk_fetch #(
  parameter int W     = 32,
  parameter int IAW   = 8,
  parameter int SLOTS = 6,
  parameter int OPW   = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           take_slot,
  input  logic           take_lit,
  input  logic           redirect,
  input  logic [IAW-1:0] target,
  output logic           imem_en,
  output logic [IAW-1:0] imem_addr,
  input  logic [W-1:0]   imem_data,
  output logic           slot_valid,
  output logic [OPW-1:0] slot_op,
  output logic           lit_valid,
  output logic [W-1:0]   lit_word
);
  localparam int QW = SLOTS * OPW;
  localparam int CW = $clog2(SLOTS + 1);

  logic [IAW-1:0] fpc;
  logic           infl;
  logic [W-1:0]   nbuf;
  logic           nbuf_v;
  logic [QW-1:0]  cur;
  logic [CW-1:0]  cnt;
  logic           refill;

  // A request is made only when the buffer is empty and nothing is in flight.
  assign imem_en    = run && !infl && !nbuf_v;
  assign imem_addr  = fpc;
  assign slot_valid = (cnt != '0);
  assign slot_op    = cur[OPW-1:0];
  assign lit_valid  = nbuf_v;
  assign lit_word   = nbuf;
  assign refill     = (cnt == '0) && nbuf_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      fpc    <= '0;
      infl   <= 1'b0;
      nbuf   <= '0;
      nbuf_v <= 1'b0;
      cur    <= '0;
      cnt    <= '0;
    end else if (redirect) begin
      fpc    <= target;
      infl   <= 1'b0;
      nbuf_v <= 1'b0;
      cnt    <= '0;
    end else begin
      if (infl) begin
        nbuf   <= imem_data;
        nbuf_v <= 1'b1;
        infl   <= 1'b0;
      end
      if (imem_en) begin
        fpc  <= fpc + 1'b1;
        infl <= 1'b1;
      end
      if (take_lit || refill) nbuf_v <= 1'b0;
      if (refill) begin
        cur <= nbuf[QW-1:0];
        cnt <= CW'(SLOTS);
      end else if (take_slot) begin
        cur <= cur >> OPW;
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/stk_stack.sv
// Data stack held in a small register array; top and second entries read out.
module stk_stack #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     pop_cnt,
  input  logic           push,
  input  logic [W-1:0]   push_val,
  input  logic           swap,
  output logic [W-1:0]   tos,
  output logic [W-1:0]   nos,
  output logic [SPW-1:0] depth
);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] base;
  logic [SPW-1:0] sp_m1;
  logic [SPW-1:0] sp_m2;

  assign sp_m1 = sp - SPW'(1);
  assign sp_m2 = sp - SPW'(2);
  assign base  = sp - SPW'(pop_cnt);
  assign tos   = mem[IW'(sp_m1)];
  assign nos   = mem[IW'(sp_m2)];
  assign depth = sp;

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else     sp <= base + SPW'(push);
  end

  always_ff @(posedge clk) begin
    if (push) mem[IW'(base)] <= push_val;
    if (swap) begin
      mem[IW'(sp_m1)] <= nos;
      mem[IW'(sp_m2)] <= tos;
    end
  end
endmodule

// File: rtl/stk_mul.sv
// Shift-and-add multiplier, one partial product per cycle, W cycles per product.
module stk_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         valid,
  output logic [W-1:0] result
);
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  acc;
  logic [W-1:0]  mc;
  logic [W-1:0]  mp;
  logic [LW-1:0] left;

  assign busy   = (left != '0);
  assign result = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      mc    <= '0;
      mp    <= '0;
      left  <= '0;
      valid <= 1'b0;
    end else if (start) begin
      acc   <= '0;
      mc    <= a;
      mp    <= b;
      left  <= LW'(W);
      valid <= 1'b0;
    end else if (busy) begin
      if (mp[0]) acc <= acc + mc;
      mc   <= mc << 1;
      mp   <= mp >> 1;
      left <= left - 1'b1;
      if (left == LW'(1)) valid <= 1'b1;
    end
  end
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int W     = 32,
  parameter int IAW   = 8,
  parameter int DAW   = 8,
  parameter int DEPTH = 16,
  parameter int SLOTS = 6,
  parameter int OPW   = 5,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  output logic           imem_en,
  output logic [IAW-1:0] imem_addr,
  input  logic [W-1:0]   imem_data,
  output logic           dmem_re,
  output logic           dmem_we,
  output logic [DAW-1:0] dmem_addr,
  output logic [W-1:0]   dmem_wdata,
  input  logic [W-1:0]   dmem_rdata,
  output logic           halted,
  output logic           fault,
  output logic [SPW-1:0] depth,
  output logic [W-1:0]   tos
);
  logic           slot_valid, lit_valid;
  logic [OPW-1:0] slot_op;
  logic [W-1:0]   lit_word, nos;
  logic           take_slot, take_lit, redirect;
  logic [1:0]     pop_cnt;
  logic           push, swap;
  logic [W-1:0]   push_val;
  logic           mul_start, mul_busy, mul_valid;
  logic [W-1:0]   mul_res;
  logic [1:0]     ld_st;

  op_e        op;
  logic [1:0] need, pops;
  logic       grow, wr, sw, br, st, ld, mgo, hlt, hold;
  logic [W-1:0] val;
  logic       active, bad, exec;

  stk_fetch #(.W(W), .IAW(IAW), .SLOTS(SLOTS), .OPW(OPW)) u_fetch (
    .clk(clk), .rst(rst), .run(!halted),
    .take_slot(take_slot), .take_lit(take_lit),
    .redirect(redirect), .target(tos[IAW-1:0]),
    .imem_en(imem_en), .imem_addr(imem_addr), .imem_data(imem_data),
    .slot_valid(slot_valid), .slot_op(slot_op),
    .lit_valid(lit_valid), .lit_word(lit_word)
  );

  stk_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .pop_cnt(pop_cnt), .push(push),
    .push_val(push_val), .swap(swap), .tos(tos), .nos(nos), .depth(depth)
  );

  stk_mul #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .start(mul_start), .a(nos), .b(tos),
    .busy(mul_busy), .valid(mul_valid), .result(mul_res)
  );

  assign op = op_e'(slot_op);

  always_comb begin
    need = 2'd0; pops = 2'd0; grow = 1'b0; wr = 1'b0; val = '0;
    sw = 1'b0; br = 1'b0; st = 1'b0; ld = 1'b0; mgo = 1'b0;
    hlt = 1'b0; hold = 1'b0;
    case (op)
      OP_LIT:   begin grow = 1'b1; wr = 1'b1; val = lit_word; hold = !lit_valid; end
      OP_ADD:   begin need = 2'd2; pops = 2'd2; wr = 1'b1; val = nos + tos; end
      OP_SUB:   begin need = 2'd2; pops = 2'd2; wr = 1'b1; val = nos - tos; end
      OP_AND:   begin need = 2'd2; pops = 2'd2; wr = 1'b1; val = nos & tos; end
      OP_OR:    begin need = 2'd2; pops = 2'd2; wr = 1'b1; val = nos | tos; end
      OP_XOR:   begin need = 2'd2; pops = 2'd2; wr = 1'b1; val = nos ^ tos; end
      OP_NOT:   begin need = 2'd1; pops = 2'd1; wr = 1'b1; val = ~tos; end
      OP_DUP:   begin need = 2'd1; grow = 1'b1; wr = 1'b1; val = tos; end
      OP_DROP:  begin need = 2'd1; pops = 2'd1; end
      OP_SWAP:  begin need = 2'd2; sw = 1'b1; end
      OP_LOAD:  begin need = 2'd1; pops = 2'd1; ld = 1'b1; end
      OP_STORE: begin need = 2'd2; pops = 2'd2; st = 1'b1; end
      OP_JMP:   begin need = 2'd1; pops = 2'd1; br = 1'b1; end
      OP_JZ:    begin need = 2'd2; pops = 2'd2; br = (nos == '0); end
      OP_MUL:   begin need = 2'd2; pops = 2'd2; mgo = 1'b1; hold = mul_busy; end
      OP_PUSHR: begin grow = 1'b1; wr = 1'b1; val = mul_res; hold = !mul_valid; end
      OP_HALT:  hlt = 1'b1;
      default:  ;
    endcase
  end

  assign active    = !halted && (ld_st == 2'd0) && slot_valid;
  assign bad       = (depth < SPW'(need)) || (grow && (depth == SPW'(DEPTH)));
  assign exec      = active && !bad && !hold;
  assign take_slot = exec;
  assign take_lit  = exec && (op == OP_LIT);
  assign redirect  = exec && br;
  assign mul_start = exec && mgo;

  // A returning load owns the stack port; no slot runs while a load waits.
  always_comb begin
    if (ld_st == 2'd1) begin
      pop_cnt = 2'd0; push = 1'b1; push_val = dmem_rdata; swap = 1'b0;
    end else begin
      pop_cnt  = exec ? pops : 2'd0;
      push     = exec && wr;
      push_val = val;
      swap     = exec && sw;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted     <= 1'b0;
      fault      <= 1'b0;
      ld_st      <= 2'd0;
      dmem_we    <= 1'b0;
      dmem_re    <= 1'b0;
      dmem_addr  <= '0;
      dmem_wdata <= '0;
    end else begin
      dmem_we <= exec && st;
      dmem_re <= exec && ld;
      if (exec && (st || ld)) begin
        dmem_addr  <= tos[DAW-1:0];
        dmem_wdata <= nos;
      end
      if (active && bad) begin
        fault  <= 1'b1;
        halted <= 1'b1;
      end else if (exec && hlt) begin
        halted <= 1'b1;
      end
      if (exec && ld)          ld_st <= 2'd2;
      else if (ld_st != 2'd0)  ld_st <= ld_st - 2'd1;
    end
  end
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter int DEPTH = 16,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           halted,
  input logic           fault,
  input logic [SPW-1:0] depth,
  input logic           imem_en,
  input logic           dmem_we,
  input logic           dmem_re
);
  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (rst)
    depth <= SPW'(DEPTH));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  assert_fault_halts_R8: assert property (@(posedge clk) disable iff (rst)
    fault |-> halted);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_no_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    halted |-> !imem_en);

  assert_halt_no_mem_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> (!dmem_we && !dmem_re));

  assert_mem_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));
endmodule

bind stk_core stk_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .halted(halted), .fault(fault), .depth(depth),
  .imem_en(imem_en), .dmem_we(dmem_we), .dmem_re(dmem_re)
);

// File: tb/stk_core_tb.sv
module stk_core_tb;
  localparam int W = 32, IAW = 8, DAW = 8, DEPTH = 16;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int LIMIT = 3000;

  localparam int C_NOP = 0, C_LIT = 1, C_ADD = 2, C_SUB = 3, C_AND = 4, C_OR = 5;
  localparam int C_XOR = 6, C_NOT = 7, C_DUP = 8, C_DROP = 9, C_SWAP = 10;
  localparam int C_LD = 11, C_ST = 12, C_JMP = 13, C_JZ = 14, C_MUL = 15;
  localparam int C_PR = 16, C_HLT = 17;

  logic clk = 1'b0, rst = 1'b1;
  logic imem_en, dmem_re, dmem_we, halted, fault;
  logic [IAW-1:0] imem_addr;
  logic [DAW-1:0] dmem_addr;
  logic [W-1:0] imem_q, dmem_q, dmem_wdata, tos;
  logic [SPW-1:0] depth;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];

  int nchk = 0, nerr = 0;
  logic [7:0]  exp_sa[$];
  logic [31:0] exp_sd[$];
  int exp_depth;
  logic [31:0] exp_tos;
  bit exp_fault;

  always #5 clk = ~clk;

  stk_core u_dut (
    .clk(clk), .rst(rst), .imem_en(imem_en), .imem_addr(imem_addr),
    .imem_data(imem_q), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_q),
    .halted(halted), .fault(fault), .depth(depth), .tos(tos)
  );

  always @(posedge clk) begin
    if (imem_en) imem_q <= imem[imem_addr];
    if (rst) begin
      for (int i = 0; i < 256; i++) dmem[i] <= 32'(i * 3 + 1);
    end else begin
      if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
      if (dmem_re) dmem_q <= dmem[dmem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pk(input int a, input int b, input int c,
                                     input int d, input int e, input int f,
                                     input logic [1:0] hi = 2'b00);
    logic [31:0] a32 = 32'(a), b32 = 32'(b), c32 = 32'(c);
    logic [31:0] d32 = 32'(d), e32 = 32'(e), f32 = 32'(f);
    return {hi, f32[4:0], e32[4:0], d32[4:0], c32[4:0], b32[4:0], a32[4:0]};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) imem[i] = 32'h0;
  endtask

  // Behavioural interpreter: one word at a time, slots in order, literals from the stream.
  task automatic model_run();
    logic [31:0] s [16];
    logic [31:0] dm [256];
    logic [31:0] w, res;
    logic [7:0] pc;
    int sp, need, steps, op;
    bit grow, done, br;
    for (int i = 0; i < 256; i++) dm[i] = 32'(i * 3 + 1);
    exp_sa.delete(); exp_sd.delete();
    exp_fault = 0; sp = 0; pc = 0; res = 0; done = 0; steps = 0;
    while (!done && steps < 5000) begin
      steps++;
      w = imem[pc]; pc++;
      for (int k = 0; k < 6; k++) begin
        op = int'(w[5*k +: 5]);
        br = 0;
        case (op)
          C_ADD, C_SUB, C_AND, C_OR, C_XOR, C_SWAP, C_ST, C_JZ, C_MUL: need = 2;
          C_NOT, C_DUP, C_DROP, C_LD, C_JMP: need = 1;
          default: need = 0;
        endcase
        grow = (op == C_LIT) || (op == C_DUP) || (op == C_PR);
        if (sp < need || (grow && sp == DEPTH)) begin
          exp_fault = 1; done = 1;
        end else begin
          case (op)
            C_LIT:  begin s[sp] = imem[pc]; pc++; sp++; end
            C_ADD:  begin s[sp-2] = s[sp-2] + s[sp-1]; sp--; end
            C_SUB:  begin s[sp-2] = s[sp-2] - s[sp-1]; sp--; end
            C_AND:  begin s[sp-2] = s[sp-2] & s[sp-1]; sp--; end
            C_OR:   begin s[sp-2] = s[sp-2] | s[sp-1]; sp--; end
            C_XOR:  begin s[sp-2] = s[sp-2] ^ s[sp-1]; sp--; end
            C_NOT:  s[sp-1] = ~s[sp-1];
            C_DUP:  begin s[sp] = s[sp-1]; sp++; end
            C_DROP: sp--;
            C_SWAP: begin w = w; {s[sp-1], s[sp-2]} = {s[sp-2], s[sp-1]}; end
            C_LD:   s[sp-1] = dm[s[sp-1][7:0]];
            C_ST:   begin
                      dm[s[sp-1][7:0]] = s[sp-2];
                      exp_sa.push_back(s[sp-1][7:0]);
                      exp_sd.push_back(s[sp-2]);
                      sp -= 2;
                    end
            C_JMP:  begin pc = s[sp-1][7:0]; sp--; br = 1; end
            C_JZ:   begin
                      if (s[sp-2] == 0) begin pc = s[sp-1][7:0]; br = 1; end
                      sp -= 2;
                    end
            C_MUL:  begin res = s[sp-2] * s[sp-1]; sp -= 2; end
            C_PR:   begin s[sp] = res; sp++; end
            C_HLT:  done = 1;
            default: ;
          endcase
        end
        if (done || br) break;
      end
    end
    exp_depth = sp;
    exp_tos = (sp > 0) ? s[sp-1] : 32'h0;
  endtask

  task automatic run_prog(input string name);
    int cyc;
    model_run();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(depth == '0, "R10", {name, " reset depth"}, 32'(depth), 0);
    chk(!halted && !fault, "R10", {name, " reset flags"}, {30'd0, halted, fault}, 0);
    chk(imem_en && imem_addr == '0, "R10", {name, " first fetch address"}, 32'(imem_addr), 0);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      if (dmem_we && dmem_re) chk(0, "R11", {name, " read and write together"}, 1, 0);
      if (dmem_we) begin
        if (exp_sa.size() == 0) chk(0, "R5", {name, " unexpected store"}, 32'(dmem_addr), 0);
        else begin
          chk(dmem_addr == exp_sa[0], "R5", {name, " store address"}, 32'(dmem_addr), 32'(exp_sa[0]));
          chk(dmem_wdata == exp_sd[0], "R3", {name, " store data"}, dmem_wdata, exp_sd[0]);
          void'(exp_sa.pop_front()); void'(exp_sd.pop_front());
        end
      end
    end
    if (cyc >= LIMIT) chk(0, "R9", {name, " watchdog expired"}, 32'(cyc), LIMIT);
    // R9: after halting, no fetch and no memory traffic
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!imem_en && !dmem_we && !dmem_re && halted, "R9", {name, " quiet while halted"},
          {28'd0, halted, imem_en, dmem_we, dmem_re}, 32'h8);
    end
    chk(exp_sa.size() == 0, "R5", {name, " missing stores"}, 32'(exp_sa.size()), 0);
    chk(fault == exp_fault, "R8", {name, " fault flag"}, 32'(fault), 32'(exp_fault));
    chk(int'(depth) == exp_depth, "R4", {name, " final depth"}, 32'(depth), 32'(exp_depth));
    if (exp_depth > 0) chk(tos == exp_tos, "R2", {name, " final top"}, tos, exp_tos);
  endtask

  initial begin
    // R1 R2 R3 R5: literals in slot order, ALU ops, load and store, ignored top bits
    clear_prog();
    imem[0]  = pk(C_LIT, C_LIT, C_ADD, C_LIT, C_ST, C_NOP);
    imem[1]  = 32'd5; imem[2] = 32'd7; imem[3] = 32'd10;
    imem[4]  = pk(C_LIT, C_LIT, C_SUB, C_LIT, C_ST, C_NOP);
    imem[5]  = 32'd3; imem[6] = 32'd10; imem[7] = 32'd11;
    imem[8]  = pk(C_LIT, C_LIT, C_XOR, C_NOT, C_LIT, C_ST);
    imem[9]  = 32'h0000F0F0; imem[10] = 32'h00000FF0; imem[11] = 32'd12;
    imem[12] = pk(C_LIT, C_LD, C_LIT, C_AND, C_LIT, C_ST);
    imem[13] = 32'd10; imem[14] = 32'd4; imem[15] = 32'd13;
    imem[16] = pk(C_LIT, C_LIT, C_OR, 18, C_HLT, C_NOP, 2'b11);
    imem[17] = pk(C_HLT, C_HLT, C_HLT, C_HLT, C_HLT, C_HLT);
    imem[18] = 32'h00000003;
    run_prog("alu_lit");

    // R4 R6: loop with conditional branch, discarded slots, stack shuffles
    clear_prog();
    imem[0]  = pk(C_LIT, C_LIT, C_JMP, C_LIT, C_LIT, C_HLT);
    imem[1]  = 32'd3; imem[2] = 32'd3;
    imem[3]  = pk(C_DUP, C_DUP, C_ST, C_LIT, C_SUB, C_DUP);
    imem[4]  = 32'd1;
    imem[5]  = pk(C_LIT, C_JZ, C_LIT, C_JMP, C_HLT, C_HLT);
    imem[6]  = 32'd9; imem[7] = 32'd3;
    imem[8]  = pk(C_HLT, C_HLT, C_HLT, C_HLT, C_HLT, C_HLT);
    imem[9]  = pk(C_LIT, C_SWAP, C_DROP, C_LIT, C_ST, C_HLT);
    imem[10] = 32'h55; imem[11] = 32'd30;
    run_prog("branch_loop");

    // R7: multiply, result push, back-to-back multiply stall
    clear_prog();
    imem[0]  = pk(C_LIT, C_LIT, C_MUL, C_LIT, C_LIT, C_ADD);
    imem[1]  = 32'd1234; imem[2] = 32'd5678; imem[3] = 32'd1; imem[4] = 32'd2;
    imem[5]  = pk(C_PR, C_LIT, C_ST, C_PR, C_ADD, C_NOP);
    imem[6]  = 32'd40;
    imem[7]  = pk(C_LIT, C_LIT, C_MUL, C_LIT, C_LIT, C_MUL);
    imem[8]  = 32'd7; imem[9] = 32'd9; imem[10] = 32'h00010001; imem[11] = 32'h00030003;
    imem[12] = pk(C_PR, C_LIT, C_ST, C_HLT, C_NOP, C_NOP);
    imem[13] = 32'd41;
    run_prog("multiply");

    // R8: underflow on a two-operand opcode
    clear_prog();
    imem[0] = pk(C_LIT, C_ADD, C_LIT, C_ST, C_HLT, C_NOP);
    imem[1] = 32'h77; imem[2] = 32'd5;
    run_prog("underflow");

    // R8: overflow on the seventeenth entry
    clear_prog();
    imem[0] = pk(C_LIT, C_DUP, C_DUP, C_DUP, C_DUP, C_DUP);
    imem[1] = 32'd9;
    imem[2] = pk(C_DUP, C_DUP, C_DUP, C_DUP, C_DUP, C_DUP);
    imem[3] = pk(C_DUP, C_DUP, C_DUP, C_DUP, C_DUP, C_HLT);
    run_prog("overflow");

    // R9: halt in slot 0 leaves later slots unexecuted
    clear_prog();
    imem[0] = pk(C_HLT, C_LIT, C_LIT, C_ST, C_NOP, C_NOP);
    imem[1] = 32'd5; imem[2] = 32'd6;
    run_prog("halt_first");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule